// File: doc/BRIEF.md
# Phased SPI Transaction Engine

This block is the master side of a serial memory link. Software describes one transfer through a small register window and then sets a start bit. A transfer is built from up to five optional phases that always run in the same sequence: an opcode phase, an address phase, a wait phase of idle clocks, an outgoing data phase and an incoming data phase. Each phase has its own enable bit and its own length, so the same engine can issue a short control opcode, an identification read or a long burst. One mode bit selects whether the opcode, address and data travel on a single line (classic SPI, with separate out and in lines) or on four lines at once (quad).

A 16-word by 32-bit buffer holds the outgoing data before the transfer and collects the incoming data during it. Chip select can be padded by one extra clock period before the first phase and after the last, each padding enabled on its own. The serial clock is derived from the system clock by a pre-divider and a main divider with a programmable low time. A bypass mode runs one bit per system clock. Software either polls the start bit, which the engine clears at the end, or watches a one-cycle done pulse.

Top module: `spi_phase_engine`

## Requirements
- R1: Enabled phases run in the order opcode, address, wait, outgoing data, incoming data; a phase whose enable bit is clear produces no serial clocks at all.
- R2: Every length field holds the bit count minus one. The opcode phase takes 1 to 16 bits from opcode register bits [15:0], and the address phase takes 1 to 32 bits; both are sent most significant bit first, so a 2-bit opcode of value 0 acts as a plain two-clock delay.
- R3: Outgoing data is taken from buffer word 0 onward, bit 31 of each word first; incoming bits fill the buffer from word 0, bit 31 downward, and buffer bits past the received length keep their previous contents. At most 512 bits move in each direction.
- R4: Writing control bit 0 as 1 while idle starts a transfer; control bit 0 reads 1 while busy and 0 after the end, and `done` is high for exactly one cycle per start, including a start with nothing enabled.
- R5: In single-line mode the engine drives only `dq_o[0]` (enable `dq_oe` = 4'b0001) and samples incoming data on `dq_i[1]`.
- R6: In quad mode opcode, address and outgoing data leave four bits per clock on `dq_o[3:0]` with the earliest bit on lane 3 (enable 4'b1111); incoming data is sampled on `dq_i[3:0]` with lane 3 as the earliest bit; quad lengths are multiples of 4.
- R7: The wait phase lasts its programmed number of serial clocks (1 to 256) in either mode, with all lanes released.
- R8: With setup padding enabled (control bit 2) chip select goes low one serial clock period before the first phase; with hold padding enabled (control bit 3) it stays low one period after the last; no serial clock pulses during padding.
- R9: Outside bypass, each serial clock period is (PRE+1)*(N+1) system cycles, with the clock low for the first L+1 ticks and high for the remaining N-L ticks, where clock register bits [3:0]=PRE, [9:4]=N, [15:10]=L; the reset value N=1, L=0, PRE=0 gives divide-by-2 at 50% duty.
- R10: With clock register bit 31 set, one bit moves per system cycle and the serial clock is high in the low half of each system cycle.
- R11: While a transfer is running, writes to any register or buffer word are ignored.
- R12: The serial clock idles low, output data changes on the falling serial edge, input is sampled on the rising edge (on the closing edge in bypass), chip select is high and all lanes released when idle, and after reset the control register reads 0 and the clock register reads 0x10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address: 0x00-0x0F buffer, 0x10 control, 0x11 opcode, 0x12 address value, 0x13 address length, 0x14 wait length, 0x15 out length, 0x16 in length, 0x17 clock |
| wr_data | input | 32 | Register write data; length registers use bit 31 as enable |
| rd_addr | input | 5 | Read address, same map |
| rd_data | output | 32 | Read data (combinational) |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| dq_o | output | 4 | Serial data out lanes |
| dq_oe | output | 4 | Per-lane output enable |
| dq_i | input | 4 | Serial data in lanes |

## Verification
The bench acts as the serial device, presenting a fresh random nibble on every clock and recording every rising edge, so a phase emitted out of order, one clock short or long, or sent least significant bit first shows up as a stream mismatch or a wrong clock count. It targets a 2-bit opcode used as delay, a transfer with nothing enabled (which a careless design would hang on or pulse twice), full 512-bit buffers in both directions where a pointer wrap error would corrupt word 15, partial received words where a design that clears the rest of the word would fail, odd divider settings with uneven duty, and bypass mode where sampling on the wrong edge shifts incoming data by one bit. Register writes aimed at the engine in mid-transfer must leave the opcode, clock and buffer untouched.

// File: rtl/spi_phase_engine.sv
module spi_phase_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [4:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        done,
  output logic        cs_n,
  output logic        sclk,
  output logic [3:0]  dq_o,
  output logic [3:0]  dq_oe,
  input  logic [3:0]  dq_i
);
  localparam int WORDS = 16;
  localparam logic [4:0] A_CTRL = 5'h10, A_CMD = 5'h11, A_ADV = 5'h12, A_ALEN = 5'h13,
                         A_DUM = 5'h14, A_TX = 5'h15, A_RX = 5'h16, A_CLK = 5'h17;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_CMD, S_ADDR, S_DUM, S_TX, S_RX, S_HOLD} st_t;

  st_t         st;
  logic        go, quad, su_en, ho_en;
  logic [15:0] cmd_v;
  logic [3:0]  cmd_l;
  logic        cmd_e, adr_e, dum_e, tx_e, rx_e, byp;
  logic [31:0] adr_v;
  logic [4:0]  adr_l;
  logic [7:0]  dum_l;
  logic [8:0]  tx_l, rx_l, bcnt, ptr, step;
  logic [3:0]  pre_m1, pcnt;
  logic [5:0]  n_m1, lo_m1, cnt;
  logic [31:0] mem [WORDS];

  function automatic logic [2:0] next_ph(input logic [2:0] s, input logic [7:0] e);
    logic [2:0] r;
    r = 3'd0;
    for (int i = 7; i >= 1; i--)
      if (3'(i) > s && e[i]) r = 3'(i);
    return r;
  endfunction

  function automatic logic [8:0] len_of(input logic [2:0] s);
    case (s)
      3'd2:    return {5'd0, cmd_l};
      3'd3:    return {4'd0, adr_l};
      3'd4:    return {1'b0, dum_l};
      3'd5:    return tx_l;
      3'd6:    return rx_l;
      default: return 9'd0;
    endcase
  endfunction

  logic [7:0]  en_run, en_go;
  logic [2:0]  ph_first, ph_next;
  logic        shifting, driving, tick, endp, samp, last, b1, start;
  logic [3:0]  nib;
  logic [18:0] cpad;
  logic [34:0] apad;
  logic [31:0] word;
  logic        unused_wr;

  assign en_run   = {ho_en, rx_e, tx_e, dum_e, adr_e, cmd_e, su_en, 1'b0};
  assign en_go    = {wr_data[3], rx_e, tx_e, dum_e, adr_e, cmd_e, wr_data[2], 1'b0};
  assign ph_first = next_ph(3'd0, en_go);
  assign ph_next  = next_ph(st, en_run);
  assign start    = wr_en && wr_addr == A_CTRL && wr_data[0];
  assign shifting = st inside {S_CMD, S_ADDR, S_DUM, S_TX, S_RX};
  assign driving  = st inside {S_CMD, S_ADDR, S_TX};
  assign step     = (quad && st != S_DUM) ? 9'd4 : 9'd1;
  assign last     = bcnt < step;
  assign tick     = pcnt == pre_m1;
  assign endp     = byp | (tick & (cnt == n_m1));
  assign samp     = byp | (tick & (cnt == lo_m1));
  assign cpad     = {cmd_v, 3'b0};
  assign apad     = {adr_v, 3'b0};
  assign word     = mem[ptr[8:5]];
  assign unused_wr = ^wr_data[30:20];

  always_comb begin
    b1  = 1'b0;
    nib = 4'd0;
    case (st)
      S_CMD:  begin b1 = cmd_v[bcnt[3:0]];  nib = cpad[bcnt[3:0] + 5'd3 -: 4]; end
      S_ADDR: begin b1 = adr_v[bcnt[4:0]];  nib = apad[{1'b0, bcnt[4:0]} + 6'd3 -: 4]; end
      S_TX:   begin b1 = word[~ptr[4:0]];   nib = word[~ptr[4:0] -: 4]; end
      default: ;
    endcase
  end

  assign cs_n  = st == S_IDLE;
  assign sclk  = shifting & (byp ? ~clk : (cnt > lo_m1));
  assign dq_o  = quad ? nib : {3'b0, b1};
  assign dq_oe = driving ? (quad ? 4'hF : 4'h1) : 4'h0;

  always_comb begin
    rd_data = 32'd0;
    if (!rd_addr[4]) rd_data = mem[rd_addr[3:0]];
    else case (rd_addr)
      A_CTRL: rd_data = {28'd0, ho_en, su_en, quad, go};
      A_CMD:  rd_data = {cmd_e, 11'd0, cmd_l, cmd_v};
      A_ADV:  rd_data = adr_v;
      A_ALEN: rd_data = {adr_e, 26'd0, adr_l};
      A_DUM:  rd_data = {dum_e, 23'd0, dum_l};
      A_TX:   rd_data = {tx_e, 22'd0, tx_l};
      A_RX:   rd_data = {rx_e, 22'd0, rx_l};
      A_CLK:  rd_data = {byp, 15'd0, lo_m1, n_m1, pre_m1};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; go <= 1'b0; done <= 1'b0;
      quad <= 1'b0; su_en <= 1'b0; ho_en <= 1'b0;
      cmd_v <= '0; cmd_l <= '0; cmd_e <= 1'b0;
      adr_v <= '0; adr_l <= '0; adr_e <= 1'b0;
      dum_l <= '0; dum_e <= 1'b0; tx_l <= '0; tx_e <= 1'b0; rx_l <= '0; rx_e <= 1'b0;
      pre_m1 <= 4'd0; n_m1 <= 6'd1; lo_m1 <= 6'd0; byp <= 1'b0;
      bcnt <= '0; ptr <= '0; pcnt <= '0; cnt <= '0;
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (wr_en) begin
          if (!wr_addr[4]) mem[wr_addr[3:0]] <= wr_data;
          case (wr_addr)
            A_CTRL: begin quad <= wr_data[1]; su_en <= wr_data[2]; ho_en <= wr_data[3]; end
            A_CMD:  begin cmd_v <= wr_data[15:0]; cmd_l <= wr_data[19:16]; cmd_e <= wr_data[31]; end
            A_ADV:  adr_v <= wr_data;
            A_ALEN: begin adr_l <= wr_data[4:0]; adr_e <= wr_data[31]; end
            A_DUM:  begin dum_l <= wr_data[7:0]; dum_e <= wr_data[31]; end
            A_TX:   begin tx_l <= wr_data[8:0]; tx_e <= wr_data[31]; end
            A_RX:   begin rx_l <= wr_data[8:0]; rx_e <= wr_data[31]; end
            A_CLK:  begin pre_m1 <= wr_data[3:0]; n_m1 <= wr_data[9:4];
                          lo_m1 <= wr_data[15:10]; byp <= wr_data[31]; end
            default: ;
          endcase
        end
        if (start) begin
          pcnt <= '0; cnt <= '0; ptr <= '0;
          bcnt <= len_of(ph_first);
          if (ph_first == 3'd0) done <= 1'b1;
          else begin go <= 1'b1; st <= st_t'(ph_first); end
        end
      end else begin
        pcnt <= tick ? 4'd0 : pcnt + 4'd1;
        if (tick) cnt <= (cnt == n_m1) ? 6'd0 : cnt + 6'd1;
        if (samp && st == S_RX) begin
          if (quad) mem[ptr[8:5]][~ptr[4:0] -: 4] <= dq_i;
          else      mem[ptr[8:5]][~ptr[4:0]] <= dq_i[1];
        end
        if (endp) begin
          if (last) begin
            st   <= st_t'(ph_next);
            bcnt <= len_of(ph_next);
            ptr  <= '0;
            if (ph_next == 3'd0) begin go <= 1'b0; done <= 1'b1; end
          end else begin
            bcnt <= bcnt - step;
            ptr  <= ptr + step;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_phase_engine_chk.sv
module spi_phase_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        sclk,
  input logic        done,
  input logic [3:0]  dq_oe,
  input logic        go,
  input logic        quad,
  input logic [15:0] cmd_v,
  input logic [9:4]  clk_n
);
  // R12
  idle_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
  // R12
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> dq_oe == 4'h0);
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R4
  done_clears_go_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !go);
  // R4
  busy_frames_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) !go |-> cs_n);
  // R5
  single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n) !quad |-> dq_oe[3:1] == 3'b000);
  // R11
  busy_cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
                                        (go && $past(go)) |-> ($stable(cmd_v) && $stable(clk_n) && $stable(quad)));
endmodule

bind spi_phase_engine spi_phase_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .done(done), .dq_oe(dq_oe),
  .go(go), .quad(quad), .cmd_v(cmd_v), .clk_n(n_m1)
);

// File: tb/tb_spi_phase_engine.sv
`timescale 1ns/1ps
module tb_spi_phase_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        done, cs_n, sclk;
  logic [3:0]  dq_o, dq_oe, dq_i = '0;

  spi_phase_engine dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .cs_n(cs_n), .sclk(sclk),
    .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
  );

  int total = 0, bad = 0;
  logic [3:0] pat [0:2047];
  logic [3:0] cap_o [0:2047];
  logic [3:0] cap_oe [0:2047];
  logic [3:0] eo [0:2047];
  logic [3:0] eoe [0:2047];
  int         ek [0:2047];
  int k = 0, cs_cyc = 0, hi_cyc = 0, ndone = 0;

  always @(posedge sclk) if (!cs_n) begin
    cap_o[k & 2047] = dq_o; cap_oe[k & 2047] = dq_oe; k++;
  end
  always @(negedge sclk) begin #1; dq_i = pat[k & 2047]; end
  always @(negedge clk) begin
    #1;
    if (!cs_n) cs_cyc++;
    if (sclk) hi_cyc++;
    if (done) ndone++;
  end

  bit q, su, ho, byp, ce, ae, de, te, re;
  int cl, al, dl, tl, rl, pm1, nm1, lm1;
  logic [15:0] cv;
  logic [31:0] av;
  logic [31:0] mm [0:15];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  function automatic logic [31:0] cmd_word();
    return {ce, 11'd0, 4'(cl - 1), cv};
  endfunction
  function automatic logic [31:0] clk_word();
    return {byp, 15'd0, 6'(lm1), 6'(nm1), 4'(pm1)};
  endfunction

  task automatic run(input bit poke);
    int step, nc, rxs, T, per, hexp, t, nca, ntx, noe, ndm, nbw;
    logic [31:0] d, w;
    step = q ? 4 : 1;
    for (int i = 0; i < 2048; i++) pat[i] = 4'($urandom);
    for (int i = 0; i < 16; i++) begin mm[i] = $urandom; wr(5'(i), mm[i]); end
    wr(5'h11, cmd_word());
    wr(5'h12, av);
    wr(5'h13, {ae, 26'd0, 5'(al - 1)});
    wr(5'h14, {de, 23'd0, 8'(dl - 1)});
    wr(5'h15, {te, 22'd0, 9'(tl - 1)});
    wr(5'h16, {re, 22'd0, 9'(rl - 1)});
    wr(5'h17, clk_word());
    nc = 0;
    if (ce) for (int i = cl - 1; i >= 0; i -= step) begin
      eo[nc] = q ? 4'(cv >> (i - 3)) : {3'b0, cv[i]}; eoe[nc] = q ? 4'hF : 4'h1; ek[nc] = 1; nc++;
    end
    if (ae) for (int i = al - 1; i >= 0; i -= step) begin
      eo[nc] = q ? 4'(av >> (i - 3)) : {3'b0, av[i]}; eoe[nc] = q ? 4'hF : 4'h1; ek[nc] = 1; nc++;
    end
    if (de) for (int i = 0; i < dl; i++) begin eo[nc] = 0; eoe[nc] = 0; ek[nc] = 2; nc++; end
    if (te) for (int p = 0; p < tl; p += step) begin
      w = mm[p / 32];
      eo[nc] = q ? 4'(w >> (31 - p % 32 - 3)) : {3'b0, w[31 - p % 32]};
      eoe[nc] = q ? 4'hF : 4'h1; ek[nc] = 3; nc++;
    end
    rxs = nc;
    if (re) for (int p = 0; p < rl; p += step) begin
      eo[nc] = 0; eoe[nc] = 0; ek[nc] = 4;
      if (q) mm[p / 32][31 - p % 32 -: 4] = pat[nc];
      else   mm[p / 32][31 - p % 32] = pat[nc][1];
      nc++;
    end
    T    = byp ? 1 : (pm1 + 1) * (nm1 + 1);
    per  = nc + int'(su) + int'(ho);
    hexp = byp ? nc : nc * (nm1 - lm1) * (pm1 + 1);
    k = 0; cs_cyc = 0; hi_cyc = 0; ndone = 0; dq_i = pat[0];
    wr(5'h10, {28'd0, ho, su, q, 1'b1});
    if (poke) begin
      repeat (3) @(negedge clk);
      wr(5'h11, ~cmd_word());
      wr(5'h00, 32'hDEADBEEF);
      wr(5'h17, 32'h0);
      wr(5'h10, 32'h0);
    end
    t = 0;
    while (ndone == 0 && t < 60000) begin @(negedge clk); t++; end
    chk("R4 transfer finished", 32'(ndone != 0), 1);
    repeat (3) @(negedge clk);
    nca = 0; ntx = 0; noe = 0; ndm = 0;
    for (int i = 0; i < nc && i < k; i++) begin
      if (cap_oe[i] !== eoe[i]) noe++;
      if (ek[i] == 1 && cap_o[i] !== eo[i]) nca++;
      if (ek[i] == 3 && cap_o[i] !== eo[i]) ntx++;
      if (ek[i] == 2 && cap_oe[i] !== 4'h0) ndm++;
    end
    chk("R1 serial clock count", k, nc);
    chk("R2 opcode/address bit errors", nca, 0);
    chk("R3 outgoing data bit errors", ntx, 0);
    chk(q ? "R6 quad lane enables" : "R5 single lane enables", noe, 0);
    if (de) chk("R7 wait phase lanes released", ndm, 0);
    chk("R8 chip select low cycles", cs_cyc, per * T);
    chk(byp ? "R10 bypass clock high cycles" : "R9 divided clock high cycles", hi_cyc, hexp);
    chk("R4 done pulse count", ndone, 1);
    rd(5'h10, d);
    chk("R4 start bit cleared", {31'd0, d[0]}, 0);
    nbw = 0;
    for (int i = 0; i < 16; i++) begin
      rd(5'(i), d);
      if (d !== mm[i]) begin
        nbw++;
        $display("  word %0d act=%0h exp=%0h", i, d, mm[i]);
      end
    end
    chk(q ? "R6 received buffer (R3)" : "R5 received buffer (R3)", nbw, 0);
    if (poke) begin
      rd(5'h11, d); chk("R11 opcode kept during busy write", d, cmd_word());
      rd(5'h17, d); chk("R11 clock kept during busy write", d, clk_word());
    end
  endtask

  task automatic defaults();
    q = 0; su = 0; ho = 0; byp = 0; ce = 0; ae = 0; de = 0; te = 0; re = 0;
    cl = 8; al = 24; dl = 4; tl = 32; rl = 32; pm1 = 0; nm1 = 1; lm1 = 0; cv = 0; av = 0;
  endtask

  initial begin
    #1900us;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset chip select high", 32'(cs_n), 1);
    chk("R12 reset sclk low", 32'(sclk), 0);
    chk("R12 reset lanes released", 32'(dq_oe), 0);
    chk("R4 reset done low", 32'(done), 0);
    rd(5'h10, d); chk("R12 reset control", d, 0);
    rd(5'h17, d); chk("R9 reset clock divider", d, 32'h10);

    // R2: identification-style read, 2-bit opcode as a delay
    defaults(); su = 1; ho = 1; ce = 1; cl = 2; cv = 16'h0; ae = 1; al = 32; av = 32'h9F000000;
    re = 1; rl = 32;
    run(0);

    // R6/R9: quad write with uneven duty divider
    defaults(); q = 1; su = 1; ce = 1; cl = 8; cv = 16'h0038; ae = 1; al = 24; av = 32'h00ABCDEF;
    te = 1; tl = 64; pm1 = 1; nm1 = 2; lm1 = 0;
    run(0);

    // R7/R10: quad read with wait phase in bypass
    defaults(); q = 1; ce = 1; cl = 8; cv = 16'h000B; ae = 1; al = 24; av = 32'h00123456;
    de = 1; dl = 6; re = 1; rl = 64; byp = 1;
    run(0);

    // R4: nothing enabled
    defaults();
    run(0);

    // R3/R11: full outgoing buffer with writes aimed at a busy engine
    defaults(); te = 1; tl = 512; ho = 1;
    run(1);

    // R3/R6: full incoming buffer in quad mode
    defaults(); q = 1; re = 1; rl = 512; ho = 1; su = 1;
    run(0);

    // R5/R3: single-line partial word receive with a 16-bit opcode
    defaults(); ce = 1; cl = 16; cv = 16'hA5C3; re = 1; rl = 45; nm1 = 3; lm1 = 1;
    run(0);

    for (int n = 0; n < 20; n++) begin
      defaults();
      q = 1'($urandom); su = 1'($urandom); ho = 1'($urandom);
      ce = 1'($urandom); ae = 1'($urandom); de = 1'($urandom); te = 1'($urandom); re = 1'($urandom);
      cl = q ? 4 * (1 + $urandom % 4) : 1 + $urandom % 16;
      al = q ? 4 * (1 + $urandom % 8) : 1 + $urandom % 32;
      dl = 1 + $urandom % 16;
      tl = q ? 4 * (1 + $urandom % 32) : 1 + $urandom % 128;
      rl = q ? 4 * (1 + $urandom % 32) : 1 + $urandom % 128;
      cv = 16'($urandom); av = $urandom;
      byp = ($urandom % 4) == 0;
      pm1 = $urandom % 2; nm1 = 1 + $urandom % 3; lm1 = $urandom % nm1;
      run(n % 5 == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule